// File: doc/BRIEF.md
# Quad Mip Level Selector

This block picks one integer mip level for a 2x2 quad of pixels before the texels are addressed. Each request carries four signed 16.16 fixed-point texture coordinate pairs, one valid bit per pixel, and the base-level size as log2 width and log2 height. It also carries a ceiling on the level index. The block chooses one row and one column of the quad and takes the absolute coordinate steps across them as the screen-space derivatives. It scales those steps into texel units with shifts, squares and sums them, and keeps the larger of the two squared lengths. The position of the leading one of that value then gives the level index, with no square root.

Requests move through a fixed eleven-register pipeline with valid/ready handshaking, so one quad can be accepted on every cycle. When the consumer holds back, the whole pipeline freezes and the output stays put. The coordinates and the pixel mask leave the block unchanged, alongside the level index, so the next stage can map them into the chosen level.

Top module: `quad_lod_select`

## Requirements
- R1: While reset is asserted and directly after it, out_valid is 0 and in_ready is 1.
- R2: With out_ready held high, a quad accepted on a rising edge appears on the outputs just after the eleventh rising edge, counting the accepting edge as the first. A new quad is accepted on every edge where in_valid and in_ready are both 1.
- R3: out_u, out_v and out_mask equal the in_u, in_v and in_mask of the same request. Pixel p occupies bits [32p+31:32p] of in_u and in_v and bit p of in_mask. Pixel 0 is upper-left, 1 upper-right, 2 lower-left and 3 lower-right.
- R4: The horizontal step is taken from pixel 2 to pixel 3 when mask bits 2 and 3 are both set, and from pixel 0 to pixel 1 otherwise.
- R5: The vertical step is taken from pixel 1 to pixel 3 when mask bits 1 and 3 are both set, and from pixel 0 to pixel 2 otherwise.
- R6: Each step's u magnitude is shifted left by in_log2_w and its v magnitude by in_log2_h. A scaled magnitude above 2^28-1 (with 16 fraction bits) saturates to 2^28-1, so out_lod never exceeds 12.
- R7: d is the larger of the two squared step lengths in texel units. For d >= 1, out_lod is floor(floor(log2 d) / 2). For example, a 2.0-texel step gives 1, and a step one LSB short of 2.0 texels gives 0.
- R8: out_lod is 0 when d is zero or below one squared texel.
- R9: out_lod is clamped to in_max_lod of the same request.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid, out_lod, out_u, out_v and out_mask keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken on this edge when in_valid is set |
| in_u | input | 128 | Four s16.16 u coordinates, pixel p at bits [32p+31:32p] |
| in_v | input | 128 | Four s16.16 v coordinates, same packing |
| in_mask | input | 4 | Per-pixel valid bits |
| in_log2_w | input | 4 | log2 of base-level width |
| in_log2_h | input | 4 | log2 of base-level height |
| in_max_lod | input | 4 | Highest level index allowed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_lod | output | 4 | Selected level index |
| out_u | output | 128 | Forwarded u coordinates |
| out_v | output | 128 | Forwarded v coordinates |
| out_mask | output | 4 | Forwarded pixel mask |

## Verification
The assertions assume that reset is low on the first clock edge and that out_ready is always at a known level. They place no limit on how out_ready may toggle; the hold rules are checked against whatever pattern the consumer produces. The random stimulus drops out_ready on about a third of the cycles, often while a result is waiting. It draws coordinate spreads from sub-texel up to near full range, so that saturation, clamping and the zero-level floor are all reached. Directed quads pin down the exact level at the row, column, shift and rounding boundaries.

// File: rtl/qls_pkg.sv
package qls_pkg;
    localparam int QLS_COORD_W = 32;
    localparam int QLS_FRAC_W  = 16;
    localparam int QLS_PIX     = 4;
    localparam int QLS_AXES    = 4;   // 0: row u, 1: row v, 2: column u, 3: column v

    typedef logic [QLS_PIX-1:0][QLS_COORD_W-1:0] qls_quad_t;
endpackage

// File: rtl/qls_absdiff.sv
module qls_absdiff #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic        [W:0]   mag_o
);
    logic signed [W:0] diff;

    always_comb begin
        diff  = $signed({b_i[W-1], b_i}) - $signed({a_i[W-1], a_i});
        mag_o = diff[W] ? (W+1)'(-diff) : (W+1)'(diff);
    end
endmodule

// File: rtl/qls_scale_sat.sv
module qls_scale_sat #(
    parameter int IN_W  = 33,
    parameter int SH_W  = 4,
    parameter int OUT_W = 28
) (
    input  logic [IN_W-1:0]  mag_i,
    input  logic [SH_W-1:0]  sh_i,
    output logic [OUT_W-1:0] scl_o
);
    localparam int WIDE_W = IN_W + (1 << SH_W) - 1;

    logic [WIDE_W-1:0] wide;
    logic              over;

    always_comb begin
        wide  = WIDE_W'(mag_i) << sh_i;
        over  = |wide[WIDE_W-1:OUT_W];
        scl_o = over ? '1 : wide[OUT_W-1:0];
    end
endmodule

// File: rtl/qls_msb.sv
module qls_msb #(
    parameter int W     = 57,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             zero_o
);
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < W; k++) begin
            if (vec_i[k]) idx_o = IDX_W'(k);
        end
        zero_o = ~|vec_i;
    end
endmodule

// File: rtl/quad_lod_select.sv
module quad_lod_select
    import qls_pkg::*;
#(
    parameter int MAG_W      = 28,
    parameter int DIM_W      = 4,
    parameter int LOD_W      = 4,
    parameter int MUL_STAGES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [QLS_PIX*QLS_COORD_W-1:0]   in_u,
    input  logic [QLS_PIX*QLS_COORD_W-1:0]   in_v,
    input  logic [QLS_PIX-1:0]               in_mask,
    input  logic [DIM_W-1:0]                 in_log2_w,
    input  logic [DIM_W-1:0]                 in_log2_h,
    input  logic [LOD_W-1:0]                 in_max_lod,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [LOD_W-1:0]                 out_lod,
    output logic [QLS_PIX*QLS_COORD_W-1:0]   out_u,
    output logic [QLS_PIX*QLS_COORD_W-1:0]   out_v,
    output logic [QLS_PIX-1:0]               out_mask
);
    localparam int DIFF_W   = QLS_COORD_W + 1;
    localparam int SQ_W     = 2 * MAG_W;
    localparam int D_W      = SQ_W + 1;
    localparam int MSB_W    = $clog2(D_W);
    localparam int STAGES   = MUL_STAGES + 7;
    localparam int UNIT_POS = 2 * QLS_FRAC_W;
    localparam int LOD_CEIL = MAG_W - QLS_FRAC_W;

    typedef struct packed {
        qls_quad_t          u;
        qls_quad_t          v;
        logic [QLS_PIX-1:0] mask;
        logic [DIM_W-1:0]   lw;
        logic [DIM_W-1:0]   lh;
        logic [LOD_W-1:0]   max_lod;
    } carry_t;

    typedef struct packed {
        logic [STAGES-1:0]                               vld;
        carry_t [STAGES-1:0]                             pl;
        logic [QLS_AXES-1:0][DIFF_W-1:0]                 mag;
        logic [QLS_AXES-1:0][MAG_W-1:0]                  scl;
        logic [MUL_STAGES-1:0][QLS_AXES-1:0][SQ_W-1:0]   sq;
        logic [D_W-1:0]                                  len_row;
        logic [D_W-1:0]                                  len_col;
        logic [D_W-1:0]                                  d;
        logic [MSB_W-1:0]                                top;
        logic                                            empty;
        logic [LOD_W-1:0]                                lod;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  adv;

    logic [QLS_AXES-1:0][QLS_COORD_W-1:0] op_a, op_b;
    logic [QLS_AXES-1:0][DIFF_W-1:0]      mag_w;
    logic [QLS_AXES-1:0][MAG_W-1:0]       scl_w;
    logic [MSB_W-1:0]                     top_w;
    logic                                 empty_w;
    logic                                 low_row, right_col;
    logic [MSB_W-1:0]                     half;

    // operand choice for the derivative estimate, from stage 0 contents
    always_comb begin
        low_row   = st_q.pl[0].mask[2] & st_q.pl[0].mask[3];
        right_col = st_q.pl[0].mask[1] & st_q.pl[0].mask[3];
        op_a[0]   = low_row   ? st_q.pl[0].u[2] : st_q.pl[0].u[0];
        op_b[0]   = low_row   ? st_q.pl[0].u[3] : st_q.pl[0].u[1];
        op_a[1]   = low_row   ? st_q.pl[0].v[2] : st_q.pl[0].v[0];
        op_b[1]   = low_row   ? st_q.pl[0].v[3] : st_q.pl[0].v[1];
        op_a[2]   = right_col ? st_q.pl[0].u[1] : st_q.pl[0].u[0];
        op_b[2]   = right_col ? st_q.pl[0].u[3] : st_q.pl[0].u[2];
        op_a[3]   = right_col ? st_q.pl[0].v[1] : st_q.pl[0].v[0];
        op_b[3]   = right_col ? st_q.pl[0].v[3] : st_q.pl[0].v[2];
    end

    for (genvar g = 0; g < QLS_AXES; g++) begin : g_axis
        qls_absdiff #(.W(QLS_COORD_W)) i_absdiff (
            .a_i   (op_a[g]),
            .b_i   (op_b[g]),
            .mag_o (mag_w[g])
        );
        if ((g % 2) == 0) begin : g_u_scale
            qls_scale_sat #(.IN_W(DIFF_W), .SH_W(DIM_W), .OUT_W(MAG_W)) i_scale (
                .mag_i (st_q.mag[g]),
                .sh_i  (st_q.pl[1].lw),
                .scl_o (scl_w[g])
            );
        end else begin : g_v_scale
            qls_scale_sat #(.IN_W(DIFF_W), .SH_W(DIM_W), .OUT_W(MAG_W)) i_scale (
                .mag_i (st_q.mag[g]),
                .sh_i  (st_q.pl[1].lh),
                .scl_o (scl_w[g])
            );
        end
    end

    qls_msb #(.W(D_W), .IDX_W(MSB_W)) i_msb (
        .vec_i  (st_q.d),
        .idx_o  (top_w),
        .zero_o (empty_w)
    );

    assign adv = ~st_q.vld[STAGES-1] | out_ready;

    always_comb begin
        st_d = st_q;
        half = '0;
        if (st_q.empty || (st_q.top < MSB_W'(UNIT_POS))) begin
            half = '0;
        end else begin
            half = (st_q.top - MSB_W'(UNIT_POS)) >> 1;
        end
        if (adv) begin
            st_d.vld[0]        = in_valid;
            st_d.pl[0].u       = in_u;
            st_d.pl[0].v       = in_v;
            st_d.pl[0].mask    = in_mask;
            st_d.pl[0].lw      = in_log2_w;
            st_d.pl[0].lh      = in_log2_h;
            st_d.pl[0].max_lod = in_max_lod;
            for (int i = 1; i < STAGES; i++) begin
                st_d.vld[i] = st_q.vld[i-1];
                st_d.pl[i]  = st_q.pl[i-1];
            end
            st_d.mag = mag_w;
            st_d.scl = scl_w;
            for (int a = 0; a < QLS_AXES; a++) begin
                st_d.sq[0][a] = SQ_W'(st_q.scl[a]) * SQ_W'(st_q.scl[a]);
            end
            for (int m = 1; m < MUL_STAGES; m++) begin
                st_d.sq[m] = st_q.sq[m-1];
            end
            st_d.len_row = D_W'(st_q.sq[MUL_STAGES-1][0]) + D_W'(st_q.sq[MUL_STAGES-1][1]);
            st_d.len_col = D_W'(st_q.sq[MUL_STAGES-1][2]) + D_W'(st_q.sq[MUL_STAGES-1][3]);
            st_d.d       = (st_q.len_row > st_q.len_col) ? st_q.len_row : st_q.len_col;
            st_d.top     = top_w;
            st_d.empty   = empty_w;
            if (half > MSB_W'(st_q.pl[STAGES-2].max_lod)) begin
                st_d.lod = st_q.pl[STAGES-2].max_lod;
            end else begin
                st_d.lod = LOD_W'(half);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = adv;
    assign out_valid = st_q.vld[STAGES-1];
    assign out_lod   = st_q.lod;
    assign out_u     = st_q.pl[STAGES-1].u;
    assign out_v     = st_q.pl[STAGES-1].v;
    assign out_mask  = st_q.pl[STAGES-1].mask;
endmodule

// File: rtl/qls_checker.sv
module qls_checker
    import qls_pkg::*;
#(
    parameter int LOD_W   = 4,
    parameter int LOD_CAP = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_ready,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [LOD_W-1:0]               out_lod,
    input logic [QLS_PIX*QLS_COORD_W-1:0] out_u,
    input logic [QLS_PIX*QLS_COORD_W-1:0] out_v,
    input logic [QLS_PIX-1:0]             out_mask
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !out_valid); // R1
    AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> out_valid); // R10
    AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> ($stable(out_lod) && $stable(out_u) && $stable(out_v) && $stable(out_mask))); // R10
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R10
    AST_LOD_CEILING: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_lod <= LOD_W'(LOD_CAP))); // R6
endmodule

bind quad_lod_select qls_checker #(
    .LOD_W   (LOD_W),
    .LOD_CAP (LOD_CEIL)
) i_qls_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_lod   (out_lod),
    .out_u     (out_u),
    .out_v     (out_v),
    .out_mask  (out_mask)
);

// File: tb/test_quad_lod_select.sv
module test_quad_lod_select;
    localparam logic [63:0] SAT = 64'((1 << 28) - 1);
    localparam logic [31:0] ONE = 32'h0001_0000;
    localparam int          N_RANDOM = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_u = '0;
    logic [127:0] in_v = '0;
    logic [3:0]   in_mask = '0;
    logic [3:0]   in_log2_w = '0;
    logic [3:0]   in_log2_h = '0;
    logic [3:0]   in_max_lod = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [3:0]   out_lod;
    logic [127:0] out_u;
    logic [127:0] out_v;
    logic [3:0]   out_mask;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    quad_lod_select i_quad_lod_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_u       (in_u),
        .in_v       (in_v),
        .in_mask    (in_mask),
        .in_log2_w  (in_log2_w),
        .in_log2_h  (in_log2_h),
        .in_max_lod (in_max_lod),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_lod    (out_lod),
        .out_u      (out_u),
        .out_v      (out_v),
        .out_mask   (out_mask)
    );

    typedef struct packed {
        logic [3:0]   lod;
        logic [127:0] u;
        logic [127:0] v;
        logic [3:0]   m;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] axis_len(input logic [31:0] a, input logic [31:0] b, input logic [3:0] sh);
        longint      da, db, df;
        logic [63:0] s;
        da = longint'($signed(a));
        db = longint'($signed(b));
        df = db - da;
        if (df < 0) df = -df;
        s = 64'(df) << sh;
        if (s > SAT) s = SAT;
        return s;
    endfunction

    function automatic logic [3:0] ref_lod(input logic [3:0][31:0] u, input logic [3:0][31:0] v,
                                           input logic [3:0] m, input logic [3:0] lw,
                                           input logic [3:0] lh, input logic [3:0] ml);
        int          r0, r1, c0, c1, lg, res;
        logic [63:0] xu, xv, yu, yv, dx, dy, d;
        if (m[2] && m[3]) begin r0 = 2; r1 = 3; end else begin r0 = 0; r1 = 1; end
        if (m[1] && m[3]) begin c0 = 1; c1 = 3; end else begin c0 = 0; c1 = 2; end
        xu = axis_len(u[r0], u[r1], lw);
        xv = axis_len(v[r0], v[r1], lh);
        yu = axis_len(u[c0], u[c1], lw);
        yv = axis_len(v[c0], v[c1], lh);
        dx = xu * xu + xv * xv;
        dy = yu * yu + yv * yv;
        d  = (dx > dy) ? dx : dy;
        lg = -1;
        for (int b = 0; b < 64; b++) begin
            if (d[b]) lg = b;
        end
        res = (lg < 32) ? 0 : (lg - 32) / 2;
        if (res > int'(ml)) res = int'(ml);
        return 4'(res);
    endfunction

    task automatic send_one(input logic [3:0][31:0] u, input logic [3:0][31:0] v, input logic [3:0] m,
                            input logic [3:0] lw, input logic [3:0] lh, input logic [3:0] ml,
                            input logic [3:0] exp, input string req);
        int n;
        @(negedge clk);
        in_u = u; in_v = v; in_mask = m;
        in_log2_w = lw; in_log2_h = lh; in_max_lod = ml;
        in_valid = 1'b1;
        out_ready = 1'b1;
        #1;
        check(in_ready == 1'b1, "R2 idle accept", 128'(in_ready), 128'(1));
        @(negedge clk);
        in_valid = 1'b0;
        n = 1;
        while (!out_valid && n < 30) begin
            @(negedge clk);
            n++;
        end
        check(n == 11, "R2 latency", 128'(n), 128'(11));
        check(out_lod == exp, req, 128'(out_lod), 128'(exp));
        check(out_u == u && out_v == v, "R3 coordinates", out_u ^ u, 128'(0));
        check(out_mask == m, "R3 mask", 128'(out_mask), 128'(m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R2: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0][31:0] u, v;
        logic [3:0]       m, lw, lh, ml;
        int               sent;
        bit               hold_pend;
        exp_t             held, e;

        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'(0));
        check(in_ready == 1'b1, "R1 in_ready in reset", 128'(in_ready), 128'(1));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'(0));
        check(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'(1));

        // R8: all coordinates equal
        send_one('0, '0, 4'hF, 4'd0, 4'd0, 4'd15, 4'd0, "R8 zero derivative");

        // R4: lower row only when pixels 2 and 3 are valid
        u = {16 * ONE, 32'd0, ONE, 32'd0}; v = '0;
        send_one(u, v, 4'b1111, 4'd0, 4'd0, 4'd15, 4'd4, "R4 lower row");
        send_one(u, v, 4'b0111, 4'd0, 4'd0, 4'd15, 4'd0, "R4 upper row");

        // R5: right column only when pixels 1 and 3 are valid
        u = '0; v = {64 * ONE, ONE, 32'd0, 32'd0};
        send_one(u, v, 4'b1111, 4'd0, 4'd0, 4'd15, 4'd6, "R5 right column");
        send_one(u, v, 4'b1101, 4'd0, 4'd0, 4'd15, 4'd5, "R5 left column");

        // R6: u scaled by width, v by height
        u = {ONE, 32'd0, ONE, 32'd0}; v = '0;
        send_one(u, v, 4'hF, 4'd10, 4'd0, 4'd15, 4'd10, "R6 width shift");
        u = '0; v = {ONE, ONE, 32'd0, 32'd0};
        send_one(u, v, 4'hF, 4'd0, 4'd6, 4'd15, 4'd6, "R6 height shift");
        send_one(u, v, 4'hF, 4'd6, 4'd0, 4'd15, 4'd0, "R6 height ignores width");

        // R9: clamp
        u = {ONE, 32'd0, ONE, 32'd0}; v = '0;
        send_one(u, v, 4'hF, 4'd10, 4'd0, 4'd3, 4'd3, "R9 clamp to 3");
        send_one(u, v, 4'hF, 4'd10, 4'd0, 4'd0, 4'd0, "R9 clamp to 0");

        // R6: saturation
        u = {2 * ONE, 32'd0, 2 * ONE, 32'd0};
        send_one(u, v, 4'hF, 4'd15, 4'd0, 4'd15, 4'd11, "R6 saturated magnitude");

        // R7 / R8: rounding boundaries and negative steps
        send_one(u, v, 4'hF, 4'd0, 4'd0, 4'd15, 4'd1, "R7 two-texel step");
        u = {2 * ONE - 1, 32'd0, 2 * ONE - 1, 32'd0};
        send_one(u, v, 4'hF, 4'd0, 4'd0, 4'd15, 4'd0, "R7 just below two texels");
        u = {ONE / 2, 32'd0, ONE / 2, 32'd0};
        send_one(u, v, 4'hF, 4'd0, 4'd0, 4'd15, 4'd0, "R8 half-texel step");
        u = {32'hFFFC_0000, 32'd0, 32'hFFFC_0000, 32'd0};
        send_one(u, v, 4'hF, 4'd0, 4'd0, 4'd15, 4'd2, "R7 negative step");

        // Random traffic with back-pressure (R2, R3, R7, R10)
        sent = 0;
        hold_pend = 1'b0;
        held = '0;
        while (sent < N_RANDOM || sb.size() > 0) begin
            @(negedge clk);
            if (sent < N_RANDOM && $urandom_range(0, 3) != 0) begin
                for (int p = 0; p < 4; p++) begin
                    u[p] = $urandom;
                    v[p] = $urandom;
                end
                if ($urandom_range(0, 2) != 0) begin
                    for (int p = 1; p < 4; p++) begin
                        u[p] = u[0] + (($urandom >> $urandom_range(6, 31)) * (($urandom_range(0, 1) == 1) ? 1 : -1));
                        v[p] = v[0] + (($urandom >> $urandom_range(6, 31)) * (($urandom_range(0, 1) == 1) ? 1 : -1));
                    end
                end
                m  = 4'($urandom_range(0, 15));
                lw = 4'($urandom_range(0, 15));
                lh = 4'($urandom_range(0, 15));
                ml = 4'($urandom_range(0, 15));
                in_u = u; in_v = v; in_mask = m;
                in_log2_w = lw; in_log2_h = lh; in_max_lod = ml;
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            out_ready = (sent >= N_RANDOM) ? 1'b1 : ($urandom_range(0, 9) < 7);
            #1;
            if (hold_pend) begin
                check(out_valid == 1'b1, "R10 valid held", 128'(out_valid), 128'(1));
                check(out_lod == held.lod && out_u == held.u && out_v == held.v && out_mask == held.m,
                      "R10 data held", 128'(out_lod), 128'(held.lod));
            end
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected output", 128'(out_valid), 128'(0));
                end else begin
                    e = sb[0];
                    check(out_lod == e.lod, "R7 random level", 128'(out_lod), 128'(e.lod));
                    check(out_u == e.u && out_v == e.v && out_mask == e.m, "R3 random forward",
                          out_u, e.u);
                    if (out_ready) void'(sb.pop_front());
                end
            end
            if (out_valid && !out_ready) begin
                check(in_ready == 1'b0, "R10 input blocked", 128'(in_ready), 128'(0));
                hold_pend = 1'b1;
                held.lod = out_lod; held.u = out_u; held.v = out_v; held.m = out_mask;
            end else begin
                hold_pend = 1'b0;
            end
            if (in_valid && in_ready) begin
                e.lod = ref_lod(in_u, in_v, in_mask, in_log2_w, in_log2_h, in_max_lod);
                e.u = in_u; e.v = in_v; e.m = in_mask;
                sb.push_back(e);
                sent++;
            end
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R2 drained", 128'(out_valid), 128'(0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule